// File: doc/BRIEF.md
# Dual Opposing Stack Storage

This block holds a small bank of byte slots that two stacks share. A data stack fills the bank from slot 0 upward, and a return stack fills it from the highest slot downward. The two meet somewhere in the middle, and any split of the bank between them is allowed. No slot has an address. Every read and write goes through one of the stacks, either as a push or pop on one stack, as a move of one value from one stack to the other, or as an exchange of the two newest data values.

Each stack's occupancy is kept as a thermometer vector with one bit per slot, so growing or shrinking a stack is a one-bit shift. The newest entries are read without a clock: the stored slots are AND-ed with one-hot masks taken from the edge of each thermometer, and the results are OR-ed together. One command is accepted per cycle. A command that cannot be honoured leaves all state as it was and raises a one-cycle error flag. A surrounding sequencer uses the block as the operand and return store of a small stack machine.

Top module: `dual_stack_store`

## Requirements
- R1: After reset both stacks are empty. `d_empty` and `r_empty` are 1, `full` is 0, both error flags are 0, and `d_top`, `d_next` and `r_top` read 0.
- R2: `cmd`=1 (data push) stores `wdata` as the new data top. From the next cycle `d_top` shows it and `d_next` shows the previous top. `cmd`=2 (data drop) removes the data top.
- R3: `cmd`=3 (return push) stores `wdata` as the new return top, and `cmd`=4 (return pop) removes it. Return values come back in last-in, first-out order on `r_top`.
- R4: The data stack grows from slot 0 upward and the return stack grows from slot DEPTH-1 downward. Together they hold exactly DEPTH entries in any split. `full` is 1 exactly when the combined count equals DEPTH.
- R5: A push (`cmd`=1 or 3) while `full` is 1 changes no output except the flags. `overflow` is 1 for the following cycle only.
- R6: A command that needs entries the stacks do not have changes no stored state, and `underflow` is 1 for the following cycle only. These commands are: drop or data-to-return on an empty data stack, pop or return-to-data on an empty return stack, and swap with fewer than two data entries.
- R7: `cmd`=5 moves the data top onto the return stack in one cycle, and this also works while `full` is 1.
- R8: `cmd`=6 moves the return top onto the data stack in one cycle, and this also works while `full` is 1.
- R9: `cmd`=7 exchanges `d_top` and `d_next` and leaves the data depth unchanged.
- R10: `cmd`=0 is idle. Only one command code is accepted per cycle, and any sequence of codes 0 to 7 keeps both stacks in last-in, first-out order.
- R11: An entry that does not exist reads as 0 on its output: `d_next` with fewer than two data entries, and `d_top` or `r_top` on an empty stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code (0 idle, 1 data push, 2 data drop, 3 return push, 4 return pop, 5 data-to-return, 6 return-to-data, 7 swap) |
| wdata | input | WIDTH | Value stored by either push |
| d_top | output | WIDTH | Newest data entry |
| d_next | output | WIDTH | Second-newest data entry |
| r_top | output | WIDTH | Newest return entry |
| d_empty | output | 1 | Data stack holds nothing |
| r_empty | output | 1 | Return stack holds nothing |
| full | output | 1 | No free slot remains |
| overflow | output | 1 | Previous command was a push while full |
| underflow | output | 1 | Previous command lacked the entries it needed |

## Verification
On every cycle the assertions check the following:
- The two occupancy vectors never claim the same slot.
- Each push, move and swap lands on the outputs one cycle later.
- A refused push or drop raises the matching flag and leaves the tops untouched.

Only the bench's scenarios can show that values come back in true last-in, first-out order across long mixed sequences, that every split of the bank between the stacks reaches exactly DEPTH entries, and that transfers at the meeting point work while the bank is full. The bench covers this by comparing every output against a queue model on each cycle.

// File: rtl/dstk_pkg.sv
package dstk_pkg;

   typedef enum logic [2:0] {
      CMD_IDLE  = 3'd0,
      CMD_DPUSH = 3'd1,
      CMD_DDROP = 3'd2,
      CMD_RPUSH = 3'd3,
      CMD_RPOP  = 3'd4,
      CMD_D2R   = 3'd5,
      CMD_R2D   = 3'd6,
      CMD_SWAP  = 3'd7
   } cmd_e;

   // where write port A lands
   typedef enum logic [1:0] {
      TGT_DFREE = 2'd0,
      TGT_RFREE = 2'd1,
      TGT_DTOP  = 2'd2
   } tgt_e;

   // what write port A carries
   typedef enum logic [1:0] {
      SRC_WDATA = 2'd0,
      SRC_DTOP  = 2'd1,
      SRC_DNEXT = 2'd2,
      SRC_RTOP  = 2'd3
   } src_e;

endpackage

// File: rtl/dstk_ptr.sv
// Thermometer occupancy pointer; GROW_UP picks which end of the bank it fills from.
module dstk_ptr #(
   parameter int DEPTH   = 16,
   parameter bit GROW_UP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grow,
   input  logic             shrink,
   output logic [DEPTH-1:0] occ,
   output logic [DEPTH-1:0] top_oh,
   output logic [DEPTH-1:0] under_oh,
   output logic [DEPTH-1:0] free_oh,
   output logic             empty,
   output logic             two_plus
);

   // therm is kept in stack order: bit 0 is the oldest slot of this stack
   logic [DEPTH-1:0] therm;
   logic [DEPTH-1:0] top_n;
   logic [DEPTH-1:0] under_n;
   logic [DEPTH-1:0] free_n;

   always_ff @(posedge clk) begin
      if (!rst_n)
         therm <= '0;
      else if (grow)
         therm <= {therm[DEPTH-2:0], 1'b1};
      else if (shrink)
         therm <= {1'b0, therm[DEPTH-1:1]};
   end

   always_comb begin
      top_n   = therm & ~{1'b0, therm[DEPTH-1:1]};
      under_n = {1'b0, top_n[DEPTH-1:1]};
      free_n  = {top_n[DEPTH-2:0], 1'b0} | {{(DEPTH-1){1'b0}}, ~therm[0]};
   end

   assign empty    = ~therm[0];
   assign two_plus = therm[1];

   generate
      if (GROW_UP) begin : g_up
         assign occ      = therm;
         assign top_oh   = top_n;
         assign under_oh = under_n;
         assign free_oh  = free_n;
      end else begin : g_down
         for (genvar i = 0; i < DEPTH; i++) begin : g_rev
            assign occ[i]      = therm[DEPTH-1-i];
            assign top_oh[i]   = top_n[DEPTH-1-i];
            assign under_oh[i] = under_n[DEPTH-1-i];
            assign free_oh[i]  = free_n[DEPTH-1-i];
         end
      end
   endgenerate

endmodule

// File: rtl/dstk_sel.sv
// One-hot AND-OR read of the slot bank.
module dstk_sel #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8
) (
   input  logic [DEPTH-1:0][WIDTH-1:0] slots,
   input  logic [DEPTH-1:0]            pick,
   output logic [WIDTH-1:0]            q
);

   always_comb begin
      q = '0;
      for (int i = 0; i < DEPTH; i++)
         q = q | (slots[i] & {WIDTH{pick[i]}});
   end

endmodule

// File: rtl/dstk_array.sv
// Slot bank with two one-hot write ports; port A wins on a shared slot.
module dstk_array #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        a_en,
   input  logic [DEPTH-1:0]            a_oh,
   input  logic [WIDTH-1:0]            a_dat,
   input  logic                        b_en,
   input  logic [DEPTH-1:0]            b_oh,
   input  logic [WIDTH-1:0]            b_dat,
   output logic [DEPTH-1:0][WIDTH-1:0] slots
);

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)
               slots[i] <= '0;
            else if (a_en && a_oh[i])
               slots[i] <= a_dat;
            else if (b_en && b_oh[i])
               slots[i] <= b_dat;
         end
      end
   endgenerate

endmodule

// File: rtl/dstk_ctl.sv
// Command legality and write steering.
module dstk_ctl
   import dstk_pkg::*;
(
   input  cmd_e cmd,
   input  logic d_empty,
   input  logic d_two,
   input  logic r_empty,
   input  logic full,
   output logic d_grow,
   output logic d_shrink,
   output logic r_grow,
   output logic r_shrink,
   output logic a_en,
   output tgt_e a_tgt,
   output src_e a_src,
   output logic b_en,
   output logic ovf,
   output logic unf
);

   always_comb begin
      d_grow   = 1'b0;
      d_shrink = 1'b0;
      r_grow   = 1'b0;
      r_shrink = 1'b0;
      a_en     = 1'b0;
      a_tgt    = TGT_DFREE;
      a_src    = SRC_WDATA;
      b_en     = 1'b0;
      ovf      = 1'b0;
      unf      = 1'b0;
      unique case (cmd)
         CMD_IDLE: ;
         CMD_DPUSH:
            if (full) ovf = 1'b1;
            else begin
               d_grow = 1'b1; a_en = 1'b1; a_tgt = TGT_DFREE; a_src = SRC_WDATA;
            end
         CMD_RPUSH:
            if (full) ovf = 1'b1;
            else begin
               r_grow = 1'b1; a_en = 1'b1; a_tgt = TGT_RFREE; a_src = SRC_WDATA;
            end
         CMD_DDROP:
            if (d_empty) unf = 1'b1;
            else d_shrink = 1'b1;
         CMD_RPOP:
            if (r_empty) unf = 1'b1;
            else r_shrink = 1'b1;
         CMD_D2R:
            if (d_empty) unf = 1'b1;
            else begin
               d_shrink = 1'b1; r_grow = 1'b1;
               a_en = 1'b1; a_tgt = TGT_RFREE; a_src = SRC_DTOP;
            end
         CMD_R2D:
            if (r_empty) unf = 1'b1;
            else begin
               r_shrink = 1'b1; d_grow = 1'b1;
               a_en = 1'b1; a_tgt = TGT_DFREE; a_src = SRC_RTOP;
            end
         CMD_SWAP:
            if (!d_two) unf = 1'b1;
            else begin
               a_en = 1'b1; a_tgt = TGT_DTOP; a_src = SRC_DNEXT; b_en = 1'b1;
            end
         default: ;
      endcase
   end

endmodule

// File: rtl/dual_stack_store.sv
module dual_stack_store
   import dstk_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cmd,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] d_top,
   output logic [WIDTH-1:0] d_next,
   output logic [WIDTH-1:0] r_top,
   output logic             d_empty,
   output logic             r_empty,
   output logic             full,
   output logic             overflow,
   output logic             underflow
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dual_stack_store: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("dual_stack_store: WIDTH must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] d_occ, d_top_oh, d_under_oh, d_free_oh;
   logic [DEPTH-1:0] r_occ, r_top_oh, r_under_oh, r_free_oh;
   logic             d_two, r_two;
   logic             d_grow, d_shrink, r_grow, r_shrink;
   logic             a_en, b_en, ovf_c, unf_c;
   tgt_e             a_tgt;
   src_e             a_src;
   logic [DEPTH-1:0] a_oh;
   logic [WIDTH-1:0] a_dat;
   logic [DEPTH-1:0][WIDTH-1:0] slots;

   dstk_ptr #(.DEPTH(DEPTH), .GROW_UP(1'b1)) u_dptr (
      .clk(clk), .rst_n(rst_n), .grow(d_grow), .shrink(d_shrink),
      .occ(d_occ), .top_oh(d_top_oh), .under_oh(d_under_oh), .free_oh(d_free_oh),
      .empty(d_empty), .two_plus(d_two)
   );

   dstk_ptr #(.DEPTH(DEPTH), .GROW_UP(1'b0)) u_rptr (
      .clk(clk), .rst_n(rst_n), .grow(r_grow), .shrink(r_shrink),
      .occ(r_occ), .top_oh(r_top_oh), .under_oh(r_under_oh), .free_oh(r_free_oh),
      .empty(r_empty), .two_plus(r_two)
   );

   assign full = &(d_occ | r_occ);

   dstk_ctl u_ctl (
      .cmd(cmd_e'(cmd)), .d_empty(d_empty), .d_two(d_two), .r_empty(r_empty), .full(full),
      .d_grow(d_grow), .d_shrink(d_shrink), .r_grow(r_grow), .r_shrink(r_shrink),
      .a_en(a_en), .a_tgt(a_tgt), .a_src(a_src), .b_en(b_en), .ovf(ovf_c), .unf(unf_c)
   );

   always_comb begin
      unique case (a_tgt)
         TGT_RFREE: a_oh = r_free_oh;
         TGT_DTOP:  a_oh = d_top_oh;
         default:   a_oh = d_free_oh;
      endcase
      unique case (a_src)
         SRC_DTOP:  a_dat = d_top;
         SRC_DNEXT: a_dat = d_next;
         SRC_RTOP:  a_dat = r_top;
         default:   a_dat = wdata;
      endcase
   end

   dstk_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_arr (
      .clk(clk), .rst_n(rst_n),
      .a_en(a_en), .a_oh(a_oh), .a_dat(a_dat),
      .b_en(b_en), .b_oh(d_under_oh), .b_dat(d_top),
      .slots(slots)
   );

   dstk_sel #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_sel_dtop  (.slots(slots), .pick(d_top_oh),   .q(d_top));
   dstk_sel #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_sel_dnext (.slots(slots), .pick(d_under_oh), .q(d_next));
   dstk_sel #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_sel_rtop  (.slots(slots), .pick(r_top_oh),   .q(r_top));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         overflow  <= 1'b0;
         underflow <= 1'b0;
      end else begin
         overflow  <= ovf_c;
         underflow <= unf_c;
      end
   end

endmodule

// File: rtl/dstk_chk.sv
module dstk_chk #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       cmd,
   input logic [WIDTH-1:0] wdata,
   input logic [WIDTH-1:0] d_top,
   input logic [WIDTH-1:0] d_next,
   input logic [WIDTH-1:0] r_top,
   input logic             d_empty,
   input logic             r_empty,
   input logic             full,
   input logic             overflow,
   input logic             underflow,
   input logic [DEPTH-1:0] d_occ,
   input logic [DEPTH-1:0] r_occ
);

   assert_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (d_occ & r_occ) == '0);

   assert_dpush_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd1 && !full) |=> (d_top == $past(wdata) && d_next == $past(d_top)));

   assert_rpush_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd3 && !full) |=> (r_top == $past(wdata)));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && (cmd == 3'd1 || cmd == 3'd3)) |=>
         (overflow && full && $stable(d_top) && $stable(r_top)));

   assert_drop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (d_empty && cmd == 3'd2) |=> (underflow && d_empty));

   assert_d2r_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd5 && !d_empty) |=> (r_top == $past(d_top)));

   assert_r2d_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd6 && !r_empty) |=> (d_top == $past(r_top)));

   assert_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd7 && d_occ[1]) |=> (d_top == $past(d_next) && d_next == $past(d_top)));

endmodule

bind dual_stack_store dstk_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd(cmd), .wdata(wdata),
   .d_top(d_top), .d_next(d_next), .r_top(r_top),
   .d_empty(d_empty), .r_empty(r_empty), .full(full),
   .overflow(overflow), .underflow(underflow),
   .d_occ(d_occ), .r_occ(r_occ)
);

// File: tb/sim_dual_stack_store.sv
module sim_dual_stack_store;

   localparam int DEPTH = 16;
   localparam int WIDTH = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2:0]       cmd = 3'd0;
   logic [WIDTH-1:0] wdata = '0;
   logic [WIDTH-1:0] d_top, d_next, r_top;
   logic             d_empty, r_empty, full, overflow, underflow;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   logic [WIDTH-1:0] dq[$];
   logic [WIDTH-1:0] rq[$];
   bit               m_ovf, m_unf;

   always #10 clk = ~clk;

   dual_stack_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .wdata(wdata),
      .d_top(d_top), .d_next(d_next), .r_top(r_top),
      .d_empty(d_empty), .r_empty(r_empty), .full(full),
      .overflow(overflow), .underflow(underflow)
   );

   // behavioural model: two queues, newest at the back
   task automatic model_apply(input logic [2:0] c, input logic [WIDTH-1:0] w);
      logic [WIDTH-1:0] t;
      bit f;
      f = (dq.size() + rq.size()) == DEPTH;
      m_ovf = 1'b0;
      m_unf = 1'b0;
      case (c)
         3'd1: if (f) m_ovf = 1'b1; else dq.push_back(w);
         3'd3: if (f) m_ovf = 1'b1; else rq.push_back(w);
         3'd2: if (dq.size() == 0) m_unf = 1'b1; else t = dq.pop_back();
         3'd4: if (rq.size() == 0) m_unf = 1'b1; else t = rq.pop_back();
         3'd5: if (dq.size() == 0) m_unf = 1'b1; else begin t = dq.pop_back(); rq.push_back(t); end
         3'd6: if (rq.size() == 0) m_unf = 1'b1; else begin t = rq.pop_back(); dq.push_back(t); end
         3'd7: if (dq.size() < 2) m_unf = 1'b1;
               else begin
                  t = dq[dq.size()-1];
                  dq[dq.size()-1] = dq[dq.size()-2];
                  dq[dq.size()-2] = t;
               end
         default: ;
      endcase
   endtask

   task automatic compare(input string tag);
      logic [3*WIDTH+4:0] exp_v, act_v;
      logic [WIDTH-1:0] e_dt, e_dn, e_rt;
      e_dt = (dq.size() > 0) ? dq[dq.size()-1] : '0;
      e_dn = (dq.size() > 1) ? dq[dq.size()-2] : '0;
      e_rt = (rq.size() > 0) ? rq[rq.size()-1] : '0;
      exp_v = {e_dt, e_dn, e_rt, dq.size() == 0, rq.size() == 0,
               (dq.size() + rq.size()) == DEPTH, m_ovf, m_unf};
      act_v = {d_top, d_next, r_top, d_empty, r_empty, full, overflow, underflow};
      total++;
      if (act_v !== exp_v) begin
         bad++;
         $display("FAIL %s: got dtop=%h dnext=%h rtop=%h de=%b re=%b full=%b ovf=%b unf=%b, want dtop=%h dnext=%h rtop=%h de=%b re=%b full=%b ovf=%b unf=%b",
                  tag, d_top, d_next, r_top, d_empty, r_empty, full, overflow, underflow,
                  e_dt, e_dn, e_rt, exp_v[4], exp_v[3], exp_v[2], exp_v[1], exp_v[0]);
      end
   endtask

   // called at a negedge: drive, let one posedge pass, check at the next negedge
   task automatic step(input logic [2:0] c, input logic [WIDTH-1:0] w, input string tag);
      cmd   = c;
      wdata = w;
      model_apply(c, w);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      m_ovf = 1'b0;
      m_unf = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R1");
      step(3'd0, 8'h00, "R1");

      // data push / drop
      step(3'd1, 8'h11, "R2");
      step(3'd1, 8'h22, "R2");
      step(3'd1, 8'h33, "R2");
      step(3'd2, 8'h00, "R2");
      // return push / pop
      step(3'd3, 8'hA1, "R3");
      step(3'd3, 8'hA2, "R3");
      step(3'd4, 8'h00, "R3");
      // swap with two entries
      step(3'd7, 8'h00, "R9");
      step(3'd2, 8'h00, "R2");
      step(3'd0, 8'h00, "R11");
      // too few entries
      step(3'd7, 8'h00, "R6");
      step(3'd2, 8'h00, "R2");
      step(3'd2, 8'h00, "R6");
      step(3'd5, 8'h00, "R6");
      step(3'd4, 8'h00, "R3");
      step(3'd4, 8'h00, "R6");
      step(3'd6, 8'h00, "R6");
      step(3'd0, 8'h00, "R11");

      // fill the bank from both ends
      for (int i = 0; i < 10; i++) step(3'd1, 8'(8'h40 + i), "R4");
      for (int i = 0; i < 6; i++)  step(3'd3, 8'(8'hC0 + i), "R4");
      step(3'd1, 8'hEE, "R5");
      step(3'd3, 8'hEF, "R5");
      step(3'd5, 8'h00, "R7");
      step(3'd6, 8'h00, "R8");
      step(3'd6, 8'h00, "R8");
      step(3'd5, 8'h00, "R7");
      step(3'd7, 8'h00, "R9");
      // drain return into data until the data stack spans the whole bank
      for (int i = 0; i < 6; i++) step(3'd6, 8'h00, "R4");
      step(3'd1, 8'h55, "R5");
      step(3'd5, 8'h00, "R7");
      // drain everything
      for (int i = 0; i < 16; i++) step(3'd2, 8'h00, "R2");
      step(3'd4, 8'h00, "R3");
      step(3'd4, 8'h00, "R6");

      // pseudo-random command mix
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[2:0], lfsr[15:8], "R10");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got no completion, want completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule